// File: doc/BRIEF.md
# Bus Access Permission Checker

This block is a slave-side firewall that sits in front of a group of bus slaves. Every incoming transaction carries the index of the slave module it targets, the requesting domain, the master ID, a read/write flag, a secure flag and an address. The block looks up a two-bit permission code for that module in the bank that belongs to the requesting domain. It grants or blocks the transaction in the same cycle.

A blocked transaction leaves a trace for software in three places. A sticky per-module violation bit is set. The first offending transaction is captured in a debug record, with a one-deep pending slot behind it. An active-low level interrupt is driven while any unmasked violation bit is set. Software programs the tables and clears the logs through a plain 32-bit register port with combinational read data. A control bit that comes out of reset set leaves the firewall open, and boot software clears it to start enforcement.

Top module: `acc_guard`

## Requirements
- R1: Module m's permission code is held in bits [2*(m%16)+1 : 2*(m%16)] of the word at byte address 0x000 + d*0x20 + (m/16)*4, where d is the requesting domain. Every permission word reads 0 after reset.
- R2: The permission codes are 0 = open, 1 = secure only (granted only when req_secure is 1), 2 = read only (denied when req_write is 1), and 3 = no access. req_grant reflects the decision in the same cycle as req_valid and is never high without req_valid.
- R3: Domains 0 to 6 each have a bank of their own. A request from domain code 7 is denied and logged like any other violation. Writes to that domain's bank addresses (0x0E0 to 0x0FF) have no effect, and those addresses read 0.
- R4: Modules 118 and above have no permission field, so their bit positions read 0 and ignore writes. A request to such a module is denied and captured in the debug record, but it sets no status bit.
- R5: A denied request sets bit m%32 of the status word at 0x100 + (m/32)*4 at the next clock edge. Writing 1 to a status bit clears it and writing 0 leaves it alone. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R6: Each status bit has a mask bit at the same position in the word at 0x120 + (m/32)*4, and all mask bits reset to 0. irq_n is low exactly while some status bit is set whose mask bit is 0.
- R7: While the debug record is empty, a violation loads it at the next edge. The word at 0x140 then reads with bit 31 = record valid, bit 24 = write flag, bits [18:16] = domain and bits [7:0] = master ID. The word at 0x144 holds the address. A held record does not change until it is cleared.
- R8: A write to 0x140 with bit 31 set clears the record at that edge. A pending violation moves into the record at the same edge; if none is pending, a violation in that same cycle loads instead. While the record is held, only one further violation waits in the pending slot and any later ones are dropped.
- R9: Bit 2 of the control word at 0x160 resets to 1. While it is 1, every valid request is granted and nothing is logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transaction present this cycle |
| req_slave | input | 7 | Target slave module index |
| req_dom | input | 3 | Requesting domain code |
| req_mst | input | 8 | Master ID |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure access |
| req_addr | input | 32 | Transaction address |
| req_grant | output | 1 | Transaction allowed |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address (writes need [1:0] = 0) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_n | output | 1 | Violation interrupt, active low, level |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a violation and the software clear of the debug record. The second pair is a violation and a write-1-to-clear of the status bit that the violation sets. The bench drives the register write and the blocked request in the same low phase of the clock. For the first pair, it checks that the record holds the new transaction rather than reading empty. For the second pair, it checks that the targeted bit stays set while the other bits in the clear pattern drop.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

   typedef enum logic [1:0] {
      PERM_OPEN   = 2'd0,
      PERM_SECURE = 2'd1,
      PERM_RDONLY = 2'd2,
      PERM_NONE   = 2'd3
   } perm_e;

   localparam logic [1:0] RGN_PERM = 2'b00;
   localparam logic [1:0] RGN_CTL  = 2'b01;

   localparam logic [2:0] SUB_STAT = 3'd0;
   localparam logic [2:0] SUB_MASK = 3'd1;
   localparam logic [2:0] SUB_DBG  = 3'd2;
   localparam logic [2:0] SUB_CTRL = 3'd3;

   localparam int CTRL_BYPASS_BIT = 2;
   localparam int DBG_VALID_BIT   = 31;
   localparam int DBG_WRITE_BIT   = 24;
   localparam int DBG_DOM_LSB     = 16;
   localparam int DBG_CLR_BIT     = 31;

endpackage

// File: rtl/acc_perm_table.sv
module acc_perm_table #(
   parameter int NUM_MODS = 118,
   parameter int NUM_DOMS = 7,
   parameter int DOM_W    = 3,
   parameter int SLV_W    = 7,
   parameter int WPD      = 8,
   parameter int WPD_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DOM_W-1:0] wr_dom,
   input  logic [WPD_W-1:0] wr_word,
   input  logic [31:0]      wr_data,
   input  logic [DOM_W-1:0] rd_dom,
   input  logic [WPD_W-1:0] rd_word,
   output logic [31:0]      rd_data,
   input  logic [DOM_W-1:0] lk_dom,
   input  logic [SLV_W-1:0] lk_mod,
   output logic [1:0]       lk_perm
);

   localparam logic [SLV_W:0] MOD_LIM = (SLV_W+1)'(NUM_MODS);

   function automatic logic [31:0] impl_bits(input int w);
      logic [31:0] r;
      r = '0;
      for (int f = 0; f < 16; f++)
         if (w * 16 + f < NUM_MODS) r[2*f +: 2] = 2'b11;
      return r;
   endfunction

   logic [31:0] tbl [NUM_DOMS][WPD];

   for (genvar d = 0; d < NUM_DOMS; d++) begin : g_dom
      for (genvar w = 0; w < WPD; w++) begin : g_word
         localparam logic [31:0] IMPL = impl_bits(w);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tbl[d][w] <= '0;
            else if (wr_en && wr_dom == DOM_W'(d) && wr_word == WPD_W'(w))
               tbl[d][w] <= wr_data & IMPL;
         end
      end
   end

   logic [31:0] lk_word;
   logic        lk_hit;

   always_comb begin
      rd_data = '0;
      lk_word = '0;
      lk_hit  = 1'b0;
      for (int d = 0; d < NUM_DOMS; d++) begin
         for (int w = 0; w < WPD; w++) begin
            if (rd_dom == DOM_W'(d) && rd_word == WPD_W'(w))
               rd_data = tbl[d][w];
            if (lk_dom == DOM_W'(d) && lk_mod[4 +: WPD_W] == WPD_W'(w)) begin
               lk_word = tbl[d][w];
               lk_hit  = 1'b1;
            end
         end
      end
      if (lk_hit && ({1'b0, lk_mod} < MOD_LIM))
         lk_perm = lk_word[{lk_mod[3:0], 1'b0} +: 2];
      else
         lk_perm = 2'b11;
   end

endmodule

// File: rtl/acc_viol_status.sv
module acc_viol_status #(
   parameter int NUM_MODS   = 118,
   parameter int STAT_WORDS = 4,
   parameter int SLV_W      = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [SLV_W-1:0] set_idx,
   input  logic             we_stat,
   input  logic             we_mask,
   input  logic [2:0]       wr_word,
   input  logic [31:0]      wr_data,
   input  logic [2:0]       rd_word,
   output logic [31:0]      rd_stat,
   output logic [31:0]      rd_mask,
   output logic             irq_n
);

   function automatic logic [31:0] impl_bits(input int w);
      logic [31:0] r;
      r = '0;
      for (int b = 0; b < 32; b++)
         if (w * 32 + b < NUM_MODS) r[b] = 1'b1;
      return r;
   endfunction

   logic [31:0] stat_q [STAT_WORDS];
   logic [31:0] mask_q [STAT_WORDS];
   logic [STAT_WORDS*32-1:0] set_vec;

   always_comb begin
      set_vec = '0;
      for (int i = 0; i < STAT_WORDS * 32; i++)
         if (set_en && set_idx == SLV_W'(i)) set_vec[i] = 1'b1;
   end

   for (genvar w = 0; w < STAT_WORDS; w++) begin : g_word
      localparam logic [31:0] IMPL = impl_bits(w);
      logic        hit;
      logic [31:0] clr;
      assign hit = (wr_word == 3'(w));
      assign clr = (we_stat && hit) ? wr_data : 32'h0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat_q[w] <= '0;
            mask_q[w] <= '0;
         end else begin
            stat_q[w] <= ((stat_q[w] & ~clr) | set_vec[w*32 +: 32]) & IMPL;
            if (we_mask && hit) mask_q[w] <= wr_data & IMPL;
         end
      end

      // R5: a bit that is not written with 1 never drops
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         !(we_stat && hit) |=> ((stat_q[w] & $past(stat_q[w])) == $past(stat_q[w])));
      // R5: a violation bit lands at the next edge, even against a clear
      a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (|set_vec[w*32 +: 32]) |=>
            ((stat_q[w] & $past(set_vec[w*32 +: 32])) == $past(set_vec[w*32 +: 32])));
   end

   always_comb begin
      logic any;
      any     = 1'b0;
      rd_stat = '0;
      rd_mask = '0;
      for (int w = 0; w < STAT_WORDS; w++) begin
         any = any | (|(stat_q[w] & ~mask_q[w]));
         if (rd_word == 3'(w)) begin
            rd_stat = stat_q[w];
            rd_mask = mask_q[w];
         end
      end
      irq_n = ~any;
   end

   // R6: the interrupt can only start after a new violation or a mask change
   a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> ($past(set_en) || $past(we_mask)));

endmodule

// File: rtl/acc_dbg_capture.sv
module acc_dbg_capture #(
   parameter int REC_W = 44
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [REC_W-1:0] cap_rec,
   input  logic             clr,
   output logic             rec_v,
   output logic [REC_W-1:0] rec
);

   logic             pend_v;
   logic [REC_W-1:0] pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_v  <= 1'b0;
         rec    <= '0;
         pend_v <= 1'b0;
         pend   <= '0;
      end else if (clr) begin
         rec_v  <= pend_v | cap_en;
         rec    <= pend_v ? pend : (cap_en ? cap_rec : '0);
         pend_v <= pend_v & cap_en;
         pend   <= (pend_v && cap_en) ? cap_rec : '0;
      end else if (cap_en) begin
         if (!rec_v) begin
            rec_v <= 1'b1;
            rec   <= cap_rec;
         end else if (!pend_v) begin
            pend_v <= 1'b1;
            pend   <= cap_rec;
         end
      end
   end

   // R8: the pending slot is only used behind a held record
   a_r8_pend_behind_rec: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v |-> rec_v);
   // R7: a held record is frozen until cleared
   a_r7_record_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_v && !clr) |=> (rec_v && $stable(rec)));

endmodule

// File: rtl/acc_guard.sv
module acc_guard
   import acc_guard_pkg::*;
#(
   parameter int NUM_MODS = 118,
   parameter int NUM_DOMS = 7,
   parameter int DOM_W    = 3,
   parameter int SLV_W    = 7,
   parameter int MST_W    = 8,
   parameter int ADDR_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [SLV_W-1:0]  req_slave,
   input  logic [DOM_W-1:0]  req_dom,
   input  logic [MST_W-1:0]  req_mst,
   input  logic              req_write,
   input  logic              req_secure,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_grant,
   input  logic              reg_we,
   input  logic [9:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_n
);

   localparam int WPD        = (NUM_MODS + 15) / 16;
   localparam int WPD_W      = $clog2(WPD);
   localparam int STAT_WORDS = (NUM_MODS + 31) / 32;
   localparam int REC_W      = ADDR_W + MST_W + DOM_W + 1;
   localparam logic [SLV_W:0] MOD_LIM = (SLV_W+1)'(NUM_MODS);

   if (NUM_MODS <= 16 || NUM_MODS > (1 << SLV_W)) begin : g_bad_mods
      $error("acc_guard: NUM_MODS out of range for SLV_W");
   end
   if (NUM_DOMS > (1 << DOM_W) || 2 + WPD_W + DOM_W > 8) begin : g_bad_bank
      $error("acc_guard: permission banks do not fit the 256-byte region");
   end
   if (STAT_WORDS > 8 || MST_W > 16 || DOM_W > 8 || ADDR_W > 32) begin : g_bad_width
      $error("acc_guard: field width exceeds register layout");
   end

   logic [1:0] rgn;
   logic [2:0] sub;
   logic [2:0] wsel;
   logic       wr_ok;
   assign rgn   = reg_addr[9:8];
   assign sub   = reg_addr[7:5];
   assign wsel  = reg_addr[4:2];
   assign wr_ok = reg_we && (reg_addr[1:0] == 2'b00);

   logic ctl_wr, dbg_clr, bypass_q;
   assign ctl_wr  = wr_ok && rgn == RGN_CTL;
   assign dbg_clr = ctl_wr && sub == SUB_DBG && wsel == 3'd0 && reg_wdata[DBG_CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bypass_q <= 1'b1;
      else if (ctl_wr && sub == SUB_CTRL && wsel == 3'd0)
         bypass_q <= reg_wdata[CTRL_BYPASS_BIT];
   end

   logic [1:0]  lk_perm;
   logic [31:0] perm_rd;

   acc_perm_table #(
      .NUM_MODS(NUM_MODS), .NUM_DOMS(NUM_DOMS), .DOM_W(DOM_W),
      .SLV_W(SLV_W), .WPD(WPD), .WPD_W(WPD_W)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok && rgn == RGN_PERM),
      .wr_dom  (reg_addr[2+WPD_W +: DOM_W]),
      .wr_word (reg_addr[2 +: WPD_W]),
      .wr_data (reg_wdata),
      .rd_dom  (reg_addr[2+WPD_W +: DOM_W]),
      .rd_word (reg_addr[2 +: WPD_W]),
      .rd_data (perm_rd),
      .lk_dom  (req_dom),
      .lk_mod  (req_slave),
      .lk_perm (lk_perm)
   );

   perm_e perm;
   logic  allow, viol, in_mod;
   assign perm   = perm_e'(lk_perm);
   assign in_mod = {1'b0, req_slave} < MOD_LIM;

   always_comb begin
      case (perm)
         PERM_OPEN:   allow = 1'b1;
         PERM_SECURE: allow = req_secure;
         PERM_RDONLY: allow = !req_write;
         default:     allow = 1'b0;
      endcase
   end

   assign req_grant = req_valid && (bypass_q || allow);
   assign viol      = req_valid && !bypass_q && !allow;

   logic [31:0] stat_rd, mask_rd;

   acc_viol_status #(
      .NUM_MODS(NUM_MODS), .STAT_WORDS(STAT_WORDS), .SLV_W(SLV_W)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (viol && in_mod),
      .set_idx (req_slave),
      .we_stat (ctl_wr && sub == SUB_STAT),
      .we_mask (ctl_wr && sub == SUB_MASK),
      .wr_word (wsel),
      .wr_data (reg_wdata),
      .rd_word (wsel),
      .rd_stat (stat_rd),
      .rd_mask (mask_rd),
      .irq_n   (irq_n)
   );

   logic             rec_v;
   logic [REC_W-1:0] rec;

   acc_dbg_capture #(.REC_W(REC_W)) u_dbg (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (viol),
      .cap_rec ({req_addr, req_mst, req_dom, req_write}),
      .clr     (dbg_clr),
      .rec_v   (rec_v),
      .rec     (rec)
   );

   logic [31:0] dbg0, dbg1, ctrl_rd;

   always_comb begin
      dbg0 = '0;
      dbg0[DBG_VALID_BIT]          = rec_v;
      dbg0[DBG_WRITE_BIT]          = rec[0];
      dbg0[DBG_DOM_LSB +: DOM_W]   = rec[1 +: DOM_W];
      dbg0[0 +: MST_W]             = rec[1+DOM_W +: MST_W];
      dbg1 = '0;
      dbg1[ADDR_W-1:0]             = rec[1+DOM_W+MST_W +: ADDR_W];
      ctrl_rd = '0;
      ctrl_rd[CTRL_BYPASS_BIT]     = bypass_q;
   end

   always_comb begin
      reg_rdata = '0;
      if (rgn == RGN_PERM)
         reg_rdata = perm_rd;
      else if (rgn == RGN_CTL) begin
         case (sub)
            SUB_STAT: reg_rdata = stat_rd;
            SUB_MASK: reg_rdata = mask_rd;
            SUB_DBG:  reg_rdata = (wsel == 3'd0) ? dbg0 : ((wsel == 3'd1) ? dbg1 : 32'h0);
            SUB_CTRL: reg_rdata = (wsel == 3'd0) ? ctrl_rd : 32'h0;
            default:  reg_rdata = '0;
         endcase
      end
   end

   // R9: while the firewall is open every request passes
   a_r9_bypass_open: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_q && req_valid) |-> req_grant);
   // R2: no grant without a request
   a_r2_no_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !req_grant);

endmodule

// File: tb/tb_acc_guard.sv
module tb_acc_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [6:0]  req_slave = '0;
   logic [2:0]  req_dom = '0;
   logic [7:0]  req_mst = '0;
   logic        req_write = 1'b0;
   logic        req_secure = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_grant;
   logic        reg_we = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_n;

   int  checks = 0;
   int  errs   = 0;
   bit  done   = 1'b0;

   always #4 clk = ~clk;

   acc_guard dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slave(req_slave),
      .req_dom(req_dom), .req_mst(req_mst), .req_write(req_write),
      .req_secure(req_secure), .req_addr(req_addr), .req_grant(req_grant),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_n(irq_n)
   );

   // vector fields: [12:6] slave, [5:3] domain, [2] write, [1] secure, [0] expected grant
   localparam int NV = 13;
   localparam logic [12:0] VEC [NV] = '{
      {7'd0,   3'd0, 1'b1, 1'b0, 1'b1},
      {7'd1,   3'd0, 1'b0, 1'b0, 1'b0},
      {7'd1,   3'd0, 1'b1, 1'b1, 1'b1},
      {7'd2,   3'd0, 1'b0, 1'b0, 1'b1},
      {7'd2,   3'd0, 1'b1, 1'b1, 1'b0},
      {7'd3,   3'd0, 1'b0, 1'b1, 1'b0},
      {7'd1,   3'd1, 1'b0, 1'b1, 1'b0},
      {7'd1,   3'd2, 1'b1, 1'b0, 1'b1},
      {7'd117, 3'd4, 1'b1, 1'b0, 1'b0},
      {7'd117, 3'd4, 1'b0, 1'b0, 1'b1},
      {7'd117, 3'd0, 1'b1, 1'b0, 1'b1},
      {7'd5,   3'd7, 1'b0, 1'b1, 1'b0},
      {7'd120, 3'd0, 1'b0, 1'b1, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic acc(input logic [6:0] s, input logic [2:0] dm, input logic w,
                      input logic sec, input logic [7:0] m, input logic [31:0] ad,
                      output logic g);
      @(negedge clk);
      req_valid = 1'b1; req_slave = s; req_dom = dm; req_write = w;
      req_secure = sec; req_mst = m; req_addr = ad;
      #1 g = req_grant;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic        g;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      chk("R6 reset irq_n", {31'b0, irq_n}, 32'h1);
      rd(10'h160, d); chk("R9 reset ctrl", d, 32'h4);
      rd(10'h140, d); chk("R7 reset dbg0", d, 32'h0);
      rd(10'h100, d); chk("R5 reset status", d, 32'h0);
      rd(10'h000, d); chk("R1 reset perm", d, 32'h0);

      // program permissions
      wr(10'h000, 32'h0000_00E4);
      wr(10'h020, 32'h0000_000C);
      wr(10'h09C, 32'h0000_0800);
      wr(10'h0BC, 32'hFFFF_FFFF);
      wr(10'h0E0, 32'hFFFF_FFFF);
      rd(10'h000, d); chk("R1 perm readback", d, 32'h0000_00E4);
      rd(10'h020, d); chk("R1 bank d1 readback", d, 32'h0000_000C);
      rd(10'h0BC, d); chk("R4 unimplemented fields", d, 32'h0000_0FFF);
      rd(10'h0E0, d); chk("R3 domain 7 bank", d, 32'h0);

      // open firewall: denied code passes, nothing logged
      acc(7'd3, 3'd0, 1'b0, 1'b0, 8'h01, 32'h10, g);
      chk("R9 bypass grant", {31'b0, g}, 32'h1);
      rd(10'h100, d); chk("R9 bypass no status", d, 32'h0);
      rd(10'h140, d); chk("R9 bypass no record", d, 32'h0);
      wr(10'h160, 32'h0);
      rd(10'h160, d); chk("R9 ctrl cleared", d, 32'h0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         acc(VEC[i][12:6], VEC[i][5:3], VEC[i][2], VEC[i][1], 8'(8'h10 + i),
             32'h1000 + 32'(i), g);
         chk($sformatf("R2/R3/R4 vector %0d", i), {31'b0, g}, {31'b0, VEC[i][0]});
      end

      rd(10'h100, d); chk("R5 status word 0", d, 32'h0000_002E);
      rd(10'h10C, d); chk("R5/R4 status word 3", d, 32'h0020_0000);
      chk("R6 irq asserted", {31'b0, irq_n}, 32'h0);
      rd(10'h140, d); chk("R7 first record dbg0", d, 32'h8000_0011);
      rd(10'h144, d); chk("R7 first record dbg1", d, 32'h0000_1001);
      wr(10'h140, 32'h8000_0000);
      rd(10'h140, d); chk("R8 pending moved dbg0", d, 32'h8100_0014);
      rd(10'h144, d); chk("R8 pending moved dbg1", d, 32'h0000_1004);
      wr(10'h140, 32'h8000_0000);
      rd(10'h140, d); chk("R8 third dropped dbg0", d, 32'h0);
      rd(10'h144, d); chk("R8 third dropped dbg1", d, 32'h0);

      // out-of-range module: captured, no status bit
      acc(7'd120, 3'd2, 1'b0, 1'b0, 8'h33, 32'hABC, g);
      chk("R4 out-of-range denied", {31'b0, g}, 32'h0);
      rd(10'h140, d); chk("R4 out-of-range captured", d, 32'h8002_0033);
      rd(10'h10C, d); chk("R4 no status bit", d, 32'h0020_0000);
      rd(10'h100, d); chk("R4 status word 0 unchanged", d, 32'h0000_002E);

      // same cycle: clear command and a new violation
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 10'h140; reg_wdata = 32'h8000_0000;
      req_valid = 1'b1; req_slave = 7'd2; req_dom = 3'd0; req_write = 1'b1;
      req_secure = 1'b0; req_mst = 8'h44; req_addr = 32'h2222;
      @(negedge clk);
      reg_we = 1'b0; req_valid = 1'b0;
      rd(10'h140, d); chk("R8 clear with violation dbg0", d, 32'h8100_0044);
      rd(10'h144, d); chk("R8 clear with violation dbg1", d, 32'h0000_2222);

      // write-1-to-clear
      wr(10'h100, 32'h0000_000A);
      rd(10'h100, d); chk("R5 w1c", d, 32'h0000_0024);
      wr(10'h100, 32'h0);
      rd(10'h100, d); chk("R5 write 0 no effect", d, 32'h0000_0024);

      // same cycle: clear of bit 3 and violation on module 3
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 10'h100; reg_wdata = 32'h0000_002C;
      req_valid = 1'b1; req_slave = 7'd3; req_dom = 3'd0; req_write = 1'b0;
      req_secure = 1'b1; req_mst = 8'h55; req_addr = 32'h3333;
      @(negedge clk);
      reg_we = 1'b0; req_valid = 1'b0;
      rd(10'h100, d); chk("R5 set wins over clear", d, 32'h0000_0008);

      // masking
      wr(10'h120, 32'h0000_0008);
      chk("R6 partly masked irq", {31'b0, irq_n}, 32'h0);
      wr(10'h12C, 32'h0020_0000);
      chk("R6 fully masked irq", {31'b0, irq_n}, 32'h1);
      rd(10'h120, d); chk("R6 mask readback", d, 32'h0000_0008);
      acc(7'd3, 3'd0, 1'b0, 1'b1, 8'h66, 32'h4444, g);
      chk("R6 masked violation quiet", {31'b0, irq_n}, 32'h1);
      acc(7'd2, 3'd0, 1'b1, 1'b1, 8'h67, 32'h5555, g);
      chk("R6 unmasked violation irq", {31'b0, irq_n}, 32'h0);

      // reopen firewall
      wr(10'h160, 32'h4);
      acc(7'd1, 3'd0, 1'b0, 1'b0, 8'h77, 32'h6666, g);
      chk("R9 reopened grant", {31'b0, g}, 32'h1);
      rd(10'h100, d); chk("R9 reopened no status", d, 32'h0000_000C);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

endmodule